// File: doc/BRIEF.md
# Per-Channel Silence Detect and Mute Flag

This block watches a stereo stream of 16-bit signed PCM samples, with a separate sample-valid strobe for each channel. Each channel has its own silence detector. A sample counts as near-silent when, after its low nibble is set aside, the bits that remain are either all zero or all one. The detector counts such samples in an unbroken run. Once the run reaches a threshold of about 300 ms of audio (13230 samples at 44.1 kHz), it declares that channel silent. Any louder sample ends the run at once.

Each channel drives a registered mute flag. The flag goes active when that channel has been declared silent, when an asynchronous system-mute input is high, or when a software soft-mute bit is set. The system-mute input passes through a two-flop synchroniser before it is used. One configuration bit picks whether both flags are active-high or active-low. The left and right detectors share nothing except the mute sources and the polarity bit.

Top module: `silence_mute_flag`

## Requirements
- R1: A sample is quiet when bits [15:4] are all 0 or all 1. Bits [3:0] have no effect. As signed values, the quiet samples are exactly -16 to +15; 0x0010, 0xFFEF, 0x7FFF and 0x8000 are not quiet.
- R2: A channel is declared silent at the clock edge that captures its HOLD_COUNT-th consecutive quiet valid sample (default 13230). The run count saturates at HOLD_COUNT, and the declaration holds while quiet samples keep arriving.
- R3: The left and right detectors are independent. Samples and strobes on one channel never change the count, the detection or the flag of the other channel.
- R4: A channel's mute flag is active when its silence is declared, OR the synchronised system mute is high, OR soft_mute is high. The flag is registered: it shows the sources sampled at the previous clock edge.
- R5: When flag_active_low is 0, the active flag level is 1. When it is 1, the active level is 0 and the inactive level is 1. A change of polarity appears on both flags one edge after it is sampled.
- R6: sys_mute_in is synchronised through two flops. A level sampled at edge k reaches the flags at edge k+2.
- R7: A valid sample that is not quiet clears that channel's run count and its silence declaration at the edge that captures it. The flag follows one edge later.
- R8: While a channel's strobe is low, its run count and silence declaration do not change, whatever the sample value.
- R9: The synchronous active-high reset clears both run counts, both declarations and the synchroniser. It drives both flags to the inactive level for the current polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| left_pcm | input | 16 | Left channel sample, two's complement |
| left_stb | input | 1 | Left sample valid |
| right_pcm | input | 16 | Right channel sample, two's complement |
| right_stb | input | 1 | Right sample valid |
| sys_mute_in | input | 1 | Asynchronous system mute request, active high |
| soft_mute | input | 1 | Software mute control bit, active high |
| flag_active_low | input | 1 | 0: flags active-high, 1: flags active-low |
| left_mute | output | 1 | Left mute flag |
| right_mute | output | 1 | Right mute flag |

## Verification
On every cycle, the assertions check these rules: the run count stays bounded and is saturated whenever silence is declared; a loud valid sample clears the detector; an idle strobe freezes it; soft mute, and system mute after its two-flop delay, force the flags to the active level. Some behaviours only the scenarios can show. These are the exact quiet/not-quiet boundary values, the threshold being crossed on exactly the HOLD_COUNT-th sample rather than one earlier, the independence of the two channels, and the polarity inversion and reset levels. The bench compares both flags with a behavioural model on every clock, and it also makes explicit checks at those points.

// File: rtl/smf_pkg.sv
package smf_pkg;
  localparam int unsigned NUM_CH    = 2;
  localparam int unsigned CH_LEFT   = 0;
  localparam int unsigned CH_RIGHT  = 1;
  localparam int unsigned DEF_SAMPLE_W   = 16;
  localparam int unsigned DEF_IGNORE_LSB = 4;
  localparam int unsigned DEF_HOLD       = 13230;
  localparam int unsigned DEF_CNT_W      = 16;
endpackage

// File: rtl/smf_quiet_qual.sv
module smf_quiet_qual #(
  parameter int unsigned SAMPLE_W   = 16,
  parameter int unsigned IGNORE_LSB = 4
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic                quiet
);
  localparam int unsigned UPPER_W = SAMPLE_W - IGNORE_LSB;

  logic [UPPER_W-1:0] upper;

  // R1: only the bits above the ignored nibble are inspected
  assign upper = sample[SAMPLE_W-1:IGNORE_LSB];

  always_comb begin
    quiet = (&upper) | ~(|upper);
  end
endmodule

// File: rtl/smf_run_detect.sv
module smf_run_detect #(
  parameter int unsigned HOLD_COUNT = 13230,
  parameter int unsigned CNT_W      = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic quiet,
  output logic detected
);
  localparam logic [CNT_W-1:0] LIMIT      = CNT_W'(HOLD_COUNT);
  localparam logic [CNT_W-1:0] LIMIT_LESS = CNT_W'(HOLD_COUNT - 1);

  logic [CNT_W-1:0] run_cnt;
  logic             det_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      det_q   <= 1'b0;
    end else if (valid) begin
      if (!quiet) begin
        run_cnt <= '0;
        det_q   <= 1'b0;
      end else if (run_cnt != LIMIT) begin
        run_cnt <= run_cnt + 1'b1;
        det_q   <= (run_cnt == LIMIT_LESS);
      end
    end
  end

  assign detected = det_q;

  // R2: the count never passes the threshold
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= LIMIT);

  // R2: a declaration only exists with a saturated run
  assert_det_saturated_R2: assert property (@(posedge clk) disable iff (rst)
    det_q |-> (run_cnt == LIMIT));

  // R7: a loud valid sample clears count and declaration
  assert_loud_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (valid && !quiet) |=> (run_cnt == '0 && !det_q));

  // R8: an idle strobe freezes the detector
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!valid && !rst) |=> ($stable(run_cnt) && $stable(det_q)));
endmodule

// File: rtl/smf_sync2.sv
module smf_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/silence_mute_flag.sv
module silence_mute_flag
  import smf_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = DEF_SAMPLE_W,
  parameter int unsigned IGNORE_LSB = DEF_IGNORE_LSB,
  parameter int unsigned HOLD_COUNT = DEF_HOLD,
  parameter int unsigned CNT_W      = DEF_CNT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] left_pcm,
  input  logic                left_stb,
  input  logic [SAMPLE_W-1:0] right_pcm,
  input  logic                right_stb,
  input  logic                sys_mute_in,
  input  logic                soft_mute,
  input  logic                flag_active_low,
  output logic                left_mute,
  output logic                right_mute
);
  logic [NUM_CH-1:0][SAMPLE_W-1:0] pcm;
  logic [NUM_CH-1:0]               stb;
  logic [NUM_CH-1:0]               quiet;
  logic [NUM_CH-1:0]               silent;
  logic [NUM_CH-1:0]               flag_q;
  logic                            sys_mute_sync;

  assign pcm[CH_LEFT]  = left_pcm;
  assign pcm[CH_RIGHT] = right_pcm;
  assign stb[CH_LEFT]  = left_stb;
  assign stb[CH_RIGHT] = right_stb;

  smf_sync2 u_sys_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (sys_mute_in),
    .sync_out (sys_mute_sync)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    smf_quiet_qual #(
      .SAMPLE_W   (SAMPLE_W),
      .IGNORE_LSB (IGNORE_LSB)
    ) u_qual (
      .sample (pcm[ch]),
      .quiet  (quiet[ch])
    );

    smf_run_detect #(
      .HOLD_COUNT (HOLD_COUNT),
      .CNT_W      (CNT_W)
    ) u_run (
      .clk      (clk),
      .rst      (rst),
      .valid    (stb[ch]),
      .quiet    (quiet[ch]),
      .detected (silent[ch])
    );

    // R4, R5: registered OR of mute sources, then polarity
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[ch] <= flag_active_low;
      end else begin
        flag_q[ch] <= (silent[ch] | sys_mute_sync | soft_mute) ^ flag_active_low;
      end
    end
  end

  assign left_mute  = flag_q[CH_LEFT];
  assign right_mute = flag_q[CH_RIGHT];

  // R4: soft mute forces both flags active one edge later
  assert_soft_forces_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(soft_mute)) |->
      (left_mute != $past(flag_active_low) && right_mute != $past(flag_active_low)));

  // R6: a system mute request reaches the flags after the two-flop delay
  assert_sys_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) && $past(sys_mute_in, 3)) |->
      (left_mute != $past(flag_active_low) && right_mute != $past(flag_active_low)));
endmodule

// File: tb/silence_mute_flag_bench.sv
module silence_mute_flag_bench;
  localparam int HOLD = 13230;
  localparam int WATCHDOG = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] left_pcm = '0;
  logic        left_stb = 1'b0;
  logic [15:0] right_pcm = '0;
  logic        right_stb = 1'b0;
  logic        sys_mute_in = 1'b0;
  logic        soft_mute = 1'b0;
  logic        flag_active_low = 1'b0;
  logic        left_mute;
  logic        right_mute;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string phase = "R9";

  silence_mute_flag u_silence_mute_flag (
    .clk(clk), .rst(rst),
    .left_pcm(left_pcm), .left_stb(left_stb),
    .right_pcm(right_pcm), .right_stb(right_stb),
    .sys_mute_in(sys_mute_in), .soft_mute(soft_mute),
    .flag_active_low(flag_active_low),
    .left_mute(left_mute), .right_mute(right_mute)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  int  m_run [2];
  bit  m_sil [2];
  bit  m_flag[2];
  bit  m_s1, m_s2;
  bit  model_live = 1'b0;

  function automatic bit is_quiet(logic [15:0] s);
    int v;
    v = int'($signed(s));
    return (v >= -16) && (v <= 15);
  endfunction

  always @(posedge clk) begin
    logic [15:0] smp [2];
    bit          stv [2];
    cycles++;
    smp[0] = left_pcm;  stv[0] = left_stb;
    smp[1] = right_pcm; stv[1] = right_stb;
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_run[c] = 0; m_sil[c] = 0; m_flag[c] = flag_active_low;
      end
      m_s1 = 0; m_s2 = 0;
    end else begin
      for (int c = 0; c < 2; c++)
        m_flag[c] = (m_sil[c] | m_s2 | soft_mute) ^ flag_active_low;
      m_s2 = m_s1;
      m_s1 = sys_mute_in;
      for (int c = 0; c < 2; c++) begin
        if (stv[c]) begin
          if (!is_quiet(smp[c])) begin
            m_run[c] = 0; m_sil[c] = 0;
          end else if (m_run[c] < HOLD) begin
            m_run[c]++;
            m_sil[c] = (m_run[c] == HOLD);
          end
        end
      end
    end
    model_live = 1'b1;
  end

  always @(negedge clk) begin
    if (model_live) begin
      checks++;
      if (left_mute !== m_flag[0] || right_mute !== m_flag[1]) begin
        failures++;
        $display("FAIL %s model compare: actual L=%b R=%b expected L=%b R=%b",
                 phase, left_mute, right_mute, m_flag[0], m_flag[1]);
      end
    end
  end

  task automatic step(input logic [15:0] l, input logic lv,
                      input logic [15:0] r, input logic rv);
    @(negedge clk);
    left_pcm = l; left_stb = lv; right_pcm = r; right_stb = rv;
  endtask

  task automatic idle();
    step(16'h1234, 1'b0, 16'h1234, 1'b0);
  endtask

  // expect flags as active(1)/inactive(0); level derived from polarity
  task automatic expect_state(input bit l_act, input bit r_act, input string req);
    logic el, er;
    @(negedge clk);
    el = l_act ^ flag_active_low;
    er = r_act ^ flag_active_low;
    checks++;
    if (left_mute !== el || right_mute !== er) begin
      failures++;
      $display("FAIL %s: actual L=%b R=%b expected L=%b R=%b",
               req, left_mute, right_mute, el, er);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R9";
    expect_state(0, 0, "R9 reset inactive");
    @(negedge clk); rst = 1'b0;

    // R2 R1: left quiet with low-nibble noise, right loud every cycle
    phase = "R2";
    for (int i = 0; i < HOLD - 1; i++)
      step(16'(i % 16), 1'b1, 16'h1234, 1'b1);
    idle();
    expect_state(0, 0, "R2 one short of threshold");
    step(16'h000F, 1'b1, 16'h0400, 1'b1);
    idle();
    expect_state(1, 0, "R2 threshold reached, R3 right unaffected");

    // R1 R7: 0x0010 is loud and clears left
    phase = "R7";
    step(16'h0010, 1'b1, 16'h0000, 1'b0);
    idle();
    expect_state(0, 0, "R7 loud 0x0010 clears left (R1)");

    // R8 R1: right all-ones, strobe every other cycle, loud data while idle
    phase = "R8";
    for (int i = 0; i < HOLD; i++) begin
      step(16'h7FFF, 1'b0, 16'hFFF0 | 16'(i % 16), 1'b1);
      step(16'h8000, 1'b0, 16'h7FFF, 1'b0);
    end
    idle();
    expect_state(0, 1, "R8 idle strobe ignored, R1 all-ones quiet");

    // R3 R1: loud values on left leave right declared
    phase = "R3";
    step(16'h8000, 1'b1, 16'hFFFF, 1'b1);
    step(16'hFFEF, 1'b1, 16'hFFFF, 1'b1);
    idle();
    expect_state(0, 1, "R3 left activity leaves right");

    // R4: soft mute
    phase = "R4";
    @(negedge clk); soft_mute = 1'b1;
    expect_state(1, 1, "R4 soft mute both active");
    @(negedge clk); soft_mute = 1'b0;
    expect_state(0, 1, "R4 soft mute released");

    // R6: system mute latency
    phase = "R6";
    @(negedge clk); sys_mute_in = 1'b1;
    expect_state(0, 1, "R6 after edge k");
    expect_state(0, 1, "R6 after edge k+1");
    expect_state(1, 1, "R6 after edge k+2");
    sys_mute_in = 1'b0;
    repeat (3) @(negedge clk);
    expect_state(0, 1, "R6 released");

    // R5: polarity inversion
    phase = "R5";
    flag_active_low = 1'b1;
    @(negedge clk);
    checks++;
    if (left_mute !== 1'b1 || right_mute !== 1'b0) begin
      failures++;
      $display("FAIL R5 active-low levels: actual L=%b R=%b expected L=1 R=0",
               left_mute, right_mute);
    end

    // R9: reset mid-run with active-low polarity
    phase = "R9";
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (left_mute !== 1'b1 || right_mute !== 1'b1) begin
      failures++;
      $display("FAIL R9 reset inactive active-low: actual L=%b R=%b expected L=1 R=1",
               left_mute, right_mute);
    end
    rst = 1'b0;
    idle();
    expect_state(0, 0, "R9 declaration cleared by reset");
    flag_active_low = 1'b0;
    repeat (2) @(negedge clk);
    expect_state(0, 0, "R5 back to active-high");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    failures++;
    $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule